// File: doc/BRIEF.md
# Privileged Trap Return Unit

This block carries out the two trap-return instructions of a small core that has three privilege levels and an optional hypervisor layer: the supervisor return and the machine return. The core raises a one-cycle request with an instruction select. It also presents the current privilege, the virtualization flag, the machine and hypervisor status words, both saved exception PCs and its feature flags. One clock later the unit returns one of two results. The first is a completion pulse with the new status words, privilege, virtualization flag and return PC. The second is an exception pulse with a cause code, and in that case every state output equals the state that was presented.

Legality is decided by a fixed chain of checks. For a supervisor return the chain is: privilege, then the trap-supervisor-return bit, then the virtual trap bit, then target alignment. For a machine return the chain is: privilege, then target alignment, then the empty-protection-table check. The first check that fails sets the cause. When the request is legal, the interrupt-enable stack in the status word is popped. The memory-privilege bit is cleared according to the privilege spec version, and the virtualization flag is restored from the saved copy.

The status word uses these bit positions: SIE 1, MIE 3, SPIE 5, MPIE 7, SPP 8, MPP 12:11, MPRV 17, TSR 22, MPV 39. The hypervisor status word uses SPV at bit 7 and VTSR at bit 22.

Top module: `trap_return_unit`

## Requirements
- R1: A supervisor return with privilege 0 (user), or a machine return with privilege other than 3 (machine), raises an exception with cause 2 (illegal instruction).
- R2: A supervisor return at privilege 1 or 2 while the trap-supervisor-return bit (bit 22) is set raises cause 2.
- R3: A supervisor return with the hypervisor flag set, virtualization on and the virtual trap bit (hypervisor status bit 22) set raises cause 22 (virtual instruction).
- R4: When compressed support is off, a return target (saved supervisor PC for a supervisor return, saved machine PC for a machine return) with either low bit set raises cause 0 (misaligned fetch).
- R5: A machine return with protection present, a rule count of zero and a restored privilege other than 3 raises cause 1 (fetch access fault).
- R6: Checks take priority in this order. For a supervisor return: R1, R2, R3, R4. For a machine return: R1, R4, R5. On an exception, the status, hypervisor status, privilege and virtualization outputs equal the inputs that were presented.
- R7: A legal supervisor return does four things: it copies the old SPIE into SIE, it sets SPIE to 1, it clears SPP, and it makes the new privilege equal to the old SPP.
- R8: A legal machine return does five things: it copies the old MPIE into MIE, it sets MPIE to 1, it clears MPP and MPV, and it makes the new privilege equal to the old MPP.
- R9: With the version flag set, MPRV is cleared on every legal supervisor return. On a legal machine return it is cleared only when the old MPP is not 3. With the flag clear, MPRV is kept.
- R10: On a legal supervisor return with the hypervisor flag set and virtualization off, the new virtualization flag is the old SPV and SPV is cleared. Otherwise a supervisor return keeps both. On a legal machine return with the hypervisor flag set, the new virtualization flag is the old MPV.
- R11: Each request produces exactly one single-cycle pulse, either completion or exception and never both, on the clock after the request. A completion carries the selected saved PC as the return PC.
- R12: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | One-cycle return request |
| is_mret_i | input | 1 | 1 selects machine return, 0 supervisor return |
| priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| virt_i | input | 1 | Current virtualization flag |
| mstatus_i | input | 64 | Machine status word |
| hstatus_i | input | XLEN | Hypervisor status word |
| sepc_i | input | XLEN | Saved supervisor exception PC |
| mepc_i | input | XLEN | Saved machine exception PC |
| has_c_i | input | 1 | Compressed instructions supported |
| has_h_i | input | 1 | Hypervisor layer present |
| pmp_en_i | input | 1 | Memory protection present |
| pmp_rules_i | input | RULE_W | Number of configured protection rules |
| ver_new_i | input | 1 | Privilege spec version is 1.12 or later |
| done_o | output | 1 | Completion pulse |
| exc_o | output | 1 | Exception pulse |
| cause_o | output | 5 | Exception cause |
| mstatus_o | output | 64 | Updated machine status word |
| hstatus_o | output | XLEN | Updated hypervisor status word |
| priv_o | output | 2 | New privilege |
| virt_o | output | 1 | New virtualization flag |
| pc_o | output | XLEN | Return PC |

## Verification
The hardest situations to reach are the priority collisions. One example is a supervisor return at a low privilege that also has the trap bit, the virtual trap bit and a misaligned target, where only the highest-ranked cause may appear. Another is a machine return to machine mode with an empty protection table, which must complete. Random status words and PCs make these overlaps likely, and biased choices (a rule count of zero half the time, compressed support off half the time) keep the lower-ranked checks live. Directed cases then force each collision, each version-dependent MPRV outcome and each virtualization restore path.

// File: rtl/trap_return_unit.sv
module trap_return_unit #(
  parameter int XLEN   = 64,
  parameter int RULE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              is_mret_i,
  input  logic [1:0]        priv_i,
  input  logic              virt_i,
  input  logic [63:0]       mstatus_i,
  input  logic [XLEN-1:0]   hstatus_i,
  input  logic [XLEN-1:0]   sepc_i,
  input  logic [XLEN-1:0]   mepc_i,
  input  logic              has_c_i,
  input  logic              has_h_i,
  input  logic              pmp_en_i,
  input  logic [RULE_W-1:0] pmp_rules_i,
  input  logic              ver_new_i,
  output logic              done_o,
  output logic              exc_o,
  output logic [4:0]        cause_o,
  output logic [63:0]       mstatus_o,
  output logic [XLEN-1:0]   hstatus_o,
  output logic [1:0]        priv_o,
  output logic              virt_o,
  output logic [XLEN-1:0]   pc_o
);
  localparam int SIE = 1, MIE = 3, SPIE = 5, MPIE = 7, SPP = 8;
  localparam int MPP_LO = 11, MPRV = 17, TSR = 22, MPV = 39;
  localparam int H_SPV = 7, H_VTSR = 22;
  localparam logic [4:0] C_MISAL = 5'd0, C_ACC = 5'd1, C_ILL = 5'd2, C_VIRT = 5'd22;

  logic [XLEN-1:0] tgt;
  logic [1:0]      mpp;
  logic            in_m, misal, flt;
  logic [4:0]      cause;
  logic [63:0]     ms_n;
  logic [XLEN-1:0] hs_n;
  logic [1:0]      priv_n;
  logic            virt_n;

  assign tgt   = is_mret_i ? mepc_i : sepc_i;
  assign mpp   = mstatus_i[MPP_LO+1:MPP_LO];
  assign in_m  = (priv_i == 2'd3);
  assign misal = !has_c_i && (tgt[1:0] != 2'b00);

  always_comb begin
    flt   = 1'b1;
    cause = C_ILL;
    if (!is_mret_i) begin
      if (priv_i == 2'd0)                                cause = C_ILL;
      else if (mstatus_i[TSR] && !in_m)                  cause = C_ILL;
      else if (has_h_i && virt_i && hstatus_i[H_VTSR])   cause = C_VIRT;
      else if (misal)                                    cause = C_MISAL;
      else                                               flt = 1'b0;
    end else begin
      if (!in_m)                                         cause = C_ILL;
      else if (misal)                                    cause = C_MISAL;
      else if (pmp_en_i && pmp_rules_i == '0 && mpp != 2'd3) cause = C_ACC;
      else                                               flt = 1'b0;
    end
  end

  always_comb begin
    ms_n   = mstatus_i;
    hs_n   = hstatus_i;
    priv_n = priv_i;
    virt_n = virt_i;
    if (!is_mret_i) begin
      ms_n[SIE]  = mstatus_i[SPIE];
      ms_n[SPIE] = 1'b1;
      ms_n[SPP]  = 1'b0;
      if (ver_new_i) ms_n[MPRV] = 1'b0;
      priv_n = {1'b0, mstatus_i[SPP]};
      if (has_h_i && !virt_i) begin
        virt_n      = hstatus_i[H_SPV];
        hs_n[H_SPV] = 1'b0;
      end
    end else begin
      ms_n[MIE]               = mstatus_i[MPIE];
      ms_n[MPIE]              = 1'b1;
      ms_n[MPP_LO+1:MPP_LO]   = 2'd0;
      ms_n[MPV]               = 1'b0;
      if (ver_new_i && mpp != 2'd3) ms_n[MPRV] = 1'b0;
      priv_n = mpp;
      if (has_h_i) virt_n = mstatus_i[MPV];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o    <= 1'b0;
      exc_o     <= 1'b0;
      cause_o   <= '0;
      mstatus_o <= '0;
      hstatus_o <= '0;
      priv_o    <= '0;
      virt_o    <= 1'b0;
      pc_o      <= '0;
    end else begin
      done_o <= req_i && !flt;
      exc_o  <= req_i && flt;
      if (req_i) begin
        cause_o   <= flt ? cause : 5'd0;
        mstatus_o <= flt ? mstatus_i : ms_n;
        hstatus_o <= flt ? hstatus_i : hs_n;
        priv_o    <= flt ? priv_i : priv_n;
        virt_o    <= flt ? virt_i : virt_n;
        pc_o      <= tgt;
      end
    end
  end
endmodule

// File: rtl/trap_return_chk.sv
module trap_return_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_i,
  input logic            is_mret_i,
  input logic [1:0]      priv_i,
  input logic [63:0]     mstatus_i,
  input logic            done_o,
  input logic            exc_o,
  input logic [4:0]      cause_o,
  input logic [63:0]     mstatus_o,
  input logic [1:0]      priv_o
);
  // R11
  excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) !(done_o && exc_o));
  // R11
  resp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n) (done_o || exc_o) |-> $past(req_i));
  // R11
  req_answered_chk: assert property (@(posedge clk) disable iff (!rst_n) req_i |=> (done_o || exc_o));
  // R6
  exc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_o |-> (priv_o == $past(priv_i)) && (mstatus_o == $past(mstatus_i)));
  // R8
  mret_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(is_mret_i)) |-> (priv_o == $past(mstatus_i[12:11])) && (mstatus_o[12:11] == 2'd0) && mstatus_o[7]);
  // R7
  sret_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !$past(is_mret_i)) |-> (priv_o == {1'b0, $past(mstatus_i[8])}) && !mstatus_o[8] && mstatus_o[5]);
  // R1
  user_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_i) && $past(priv_i) == 2'd0) |-> exc_o && (cause_o == 5'd2));
endmodule

bind trap_return_unit trap_return_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .is_mret_i(is_mret_i), .priv_i(priv_i),
  .mstatus_i(mstatus_i), .done_o(done_o), .exc_o(exc_o), .cause_o(cause_o),
  .mstatus_o(mstatus_o), .priv_o(priv_o)
);

// File: tb/sim_trap_return_unit.sv
module sim_trap_return_unit;
  localparam int XLEN = 64, RW = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, mret = 0, virt = 0, hc = 0, hh = 0, pe = 0, ver = 0;
  logic [1:0] priv = 0;
  logic [63:0] ms = 0;
  logic [XLEN-1:0] hs = 0, sepc = 0, mepc = 0;
  logic [RW-1:0] rules = 0;
  logic done, exc, virt_o;
  logic [4:0] cause;
  logic [63:0] ms_o;
  logic [XLEN-1:0] hs_o, pc_o;
  logic [1:0] priv_o;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  trap_return_unit #(.XLEN(XLEN), .RULE_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .is_mret_i(mret), .priv_i(priv), .virt_i(virt),
    .mstatus_i(ms), .hstatus_i(hs), .sepc_i(sepc), .mepc_i(mepc), .has_c_i(hc), .has_h_i(hh),
    .pmp_en_i(pe), .pmp_rules_i(rules), .ver_new_i(ver), .done_o(done), .exc_o(exc),
    .cause_o(cause), .mstatus_o(ms_o), .hstatus_o(hs_o), .priv_o(priv_o), .virt_o(virt_o), .pc_o(pc_o));

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int exp_cause();
    logic [63:0] t = mret ? mepc : sepc;
    bit mis = !hc && (t[1:0] != 0);
    if (!mret) begin
      if (priv == 0) return 2;
      if (ms[22] && priv != 3) return 2;
      if (hh && virt && hs[22]) return 22;
      if (mis) return 0;
      return -1;
    end
    if (priv != 3) return 2;
    if (mis) return 0;
    if (pe && rules == 0 && ms[12:11] != 3) return 1;
    return -1;
  endfunction

  task automatic run_one(input string tag);
    int c;
    logic [63:0] em, eh;
    logic [1:0] ep;
    logic ev;
    c = exp_cause();
    em = ms; eh = hs; ep = priv; ev = virt;
    if (c < 0) begin
      if (!mret) begin
        em[1] = ms[5]; em[5] = 1; em[8] = 0;
        if (ver) em[17] = 0;
        ep = {1'b0, ms[8]};
        if (hh && !virt) begin ev = hs[7]; eh[7] = 0; end
      end else begin
        em[3] = ms[7]; em[7] = 1; em[12:11] = 0; em[39] = 0;
        if (ver && ms[12:11] != 3) em[17] = 0;
        ep = ms[12:11];
        if (hh) ev = ms[39];
      end
    end
    @(negedge clk); req = 1;
    @(negedge clk); req = 0;
    check(done == (c < 0) && exc == (c >= 0), {tag, " R11 pulse"}, {62'd0, exc, done}, {62'd0, c >= 0, c < 0});
    if (c >= 0) check(cause == c[4:0], {tag, " cause"}, cause, c);
    check(ms_o == em, {tag, " R7/R8/R9 mstatus"}, ms_o, em);
    check(hs_o == eh, {tag, " R10 hstatus"}, hs_o, eh);
    check(priv_o == ep && virt_o == ev, {tag, " R10 priv/virt"}, {priv_o, virt_o}, {ep, ev});
    if (c < 0) check(pc_o == (mret ? mepc : sepc), {tag, " R11 pc"}, pc_o, mret ? mepc : sepc);
    @(negedge clk);
    check(!done && !exc, {tag, " R11 single pulse"}, {done, exc}, 0);
  endtask

  task automatic base(input bit m, input logic [1:0] p);
    mret = m; priv = p; virt = 0; ms = 0; hs = 0; sepc = 64'h100; mepc = 64'h200;
    hc = 0; hh = 0; pe = 0; rules = 1; ver = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R12
    check(!done && !exc && ms_o == 0 && hs_o == 0 && pc_o == 0 && priv_o == 0 && !virt_o && cause == 0,
          "R12 reset", {done, exc}, 0);
    rst_n = 1;
    @(negedge clk);
    base(0, 0); ms[22] = 1; sepc = 64'h101; run_one("R1 R6 sret user prio");
    base(1, 1); mepc = 64'h2; pe = 1; rules = 0; run_one("R1 R6 mret from S");
    base(0, 1); ms[22] = 1; hh = 1; virt = 1; hs[22] = 1; run_one("R2 R6 tsr beats vtsr");
    base(0, 3); ms[22] = 1; ms[8] = 1; run_one("R2 tsr ignored in M");
    base(0, 1); hh = 1; virt = 1; hs[22] = 1; sepc = 64'h3; run_one("R3 R6 vtsr beats misal");
    base(0, 1); sepc = 64'h102; run_one("R4 sret misal");
    base(0, 1); sepc = 64'h102; hc = 1; run_one("R4 compressed ok");
    base(1, 3); mepc = 64'h201; pe = 1; rules = 0; run_one("R4 R6 misal beats pmp");
    base(1, 3); pe = 1; rules = 0; ms[12:11] = 1; run_one("R5 pmp empty");
    base(1, 3); pe = 1; rules = 0; ms[12:11] = 3; ver = 1; ms[17] = 1; run_one("R5 R9 pmp empty to M keeps mprv");
    base(1, 3); ms[12:11] = 0; ms[7] = 1; ms[17] = 1; ver = 1; ms[39] = 1; hh = 1; run_one("R8 R9 R10 mret");
    base(1, 3); ms[12:11] = 1; ms[17] = 1; ver = 0; run_one("R9 old version keeps mprv");
    base(0, 1); ms[5] = 1; ms[8] = 1; ms[17] = 1; ver = 1; hh = 1; hs[7] = 1; run_one("R7 R9 R10 sret spv");
    base(0, 1); hh = 1; virt = 1; hs[7] = 1; run_one("R10 sret virt on keeps spv");
    for (int i = 0; i < 3000; i++) begin
      mret = $urandom; priv = $urandom; virt = $urandom; ms = {$urandom, $urandom};
      hs = {$urandom, $urandom}; sepc = {$urandom, $urandom}; mepc = {$urandom, $urandom};
      if ($urandom % 4 != 0) begin sepc[1:0] = 0; mepc[1:0] = 0; end
      if ($urandom % 3 != 0) ms[22] = 0;
      if ($urandom % 3 != 0) hs[22] = 0;
      hc = $urandom; hh = $urandom; pe = $urandom; ver = $urandom;
      rules = ($urandom % 2) ? 0 : RW'($urandom);
      run_one("R6 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule